// File: doc/BRIEF.md
# Binary vocabulary tree quantizer

The block assigns 128-element feature descriptors to visual words and counts how often each word occurs. The words sit in a six-level binary tree. A level holds 2, 4, 8, 16, 32 and then 64 words, 126 in all. A descriptor starts at the root. At each level it is measured against the two children of its current node and moves into the nearer one. The level-6 word where it ends selects one of 64 histogram bins, and that bin is incremented.

Each level is one pipeline stage with two 16-lane squared-distance units, one for each child. A full 128-element distance therefore takes eight passes. All six stages advance together at the end of every eight-cycle slot. Once the pipeline is full, one descriptor is accepted per slot.

The tree words are loaded 16 elements at a time through a write port. A one-cycle clear zeroes the histogram. Any bin can be read at any time through a combinational read port.

Top module: `vqt_quantizer`

## Requirements
- R1: The distance to a tree word is the sum over all 128 elements of the squared difference of unsigned 8-bit values. It is compared without a square root. At each level the descriptor moves into the child with the smaller distance.
- R2: When the two child distances are equal, the left child (the even, lower index) is taken.
- R3: Word address a runs from 0 to 125. Level k (k = 1..6) occupies addresses 2^k-2 to 2^(k+1)-3. The children of node i of one level are nodes 2i and 2i+1 of the next. `wr_chunk_i` = c writes elements 16c to 16c+15, and element j within the chunk is taken from `wr_data_i[8j+7:8j]`. Descriptor element e is `desc_i[8e+7:8e]`.
- R4: Every accepted descriptor adds exactly one count, to the bin whose number equals its level-6 node index (0 to 63).
- R5: The count is visible on `rd_cnt_o` 48 clock edges after the edge that accepted the descriptor, and not before.
- R6: `desc_ready_o` is high in exactly one cycle out of every eight. A descriptor is accepted on a rising edge where both `desc_valid_i` and `desc_ready_o` are high.
- R7: `desc_ready_o` is low in any cycle where `wr_en_i` or `clr_i` is high. A `desc_valid_i` presented while ready is low adds nothing to the histogram.
- R8: A cycle with `clr_i` high sets all 64 bins to zero at the next edge.
- R9: A bin holds at 2^BIN_W-1 and does not wrap. BIN_W defaults to 16.
- R10: After reset every bin reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Descriptor can be taken this cycle |
| desc_i | input | 1024 | 128 unsigned 8-bit elements |
| wr_en_i | input | 1 | Tree word chunk write |
| wr_addr_i | input | 7 | Tree word address |
| wr_chunk_i | input | 3 | 16-element chunk within the word |
| wr_data_i | input | 128 | Chunk data |
| clr_i | input | 1 | Zero all histogram bins |
| rd_bin_i | input | 6 | Bin to read |
| rd_cnt_o | output | BIN_W | Count of the selected bin |

## Verification
A descriptor taken on one rising edge reaches its histogram bin 48 edges later: eight edges per level, six levels deep. The latency test reads the bin at the falling edge after the 47th edge, where it must still hold the old count, and again after the 48th, where it must hold the new one. The other tests wait more than 48 cycles after their last acceptance before reading any bin. Ready and clear are checked in the cycle they are driven, because `desc_ready_o` is combinational and a clear takes effect on the next edge. The bin counts are compared with a model in the bench that does the same greedy descent over its own copy of the tree words.

// File: rtl/vqt_pkg.sv
package vqt_pkg;
  localparam int DIM     = 128;
  localparam int ELEM_W  = 8;
  localparam int LANES   = 16;
  localparam int LEVELS  = 6;
  localparam int PASSES  = DIM / LANES;
  localparam int CHUNK_W = LANES * ELEM_W;
  localparam int DESC_W  = DIM * ELEM_W;
  localparam int NWORDS  = (1 << (LEVELS + 1)) - 2;
  localparam int NBINS   = 1 << LEVELS;
  localparam int SQ_W    = 2 * ELEM_W;
  localparam int PART_W  = SQ_W + $clog2(LANES);
  localparam int DIST_W  = SQ_W + $clog2(DIM);
  localparam int PASS_W  = $clog2(PASSES);
  localparam int NODE_W  = LEVELS;
  localparam int ADDR_W  = $clog2(NWORDS);
endpackage

// File: rtl/vqt_chunk_dist.sv
module vqt_chunk_dist
  import vqt_pkg::*;
(
  input  logic [CHUNK_W-1:0] a_i,
  input  logic [CHUNK_W-1:0] b_i,
  output logic [PART_W-1:0]  sum_o
);
  logic [SQ_W-1:0] sq [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ELEM_W-1:0] ea, eb, d;
    assign ea = a_i[g*ELEM_W +: ELEM_W];
    assign eb = b_i[g*ELEM_W +: ELEM_W];
    assign d  = (ea > eb) ? ea - eb : eb - ea;
    assign sq[g] = SQ_W'(d) * SQ_W'(d);
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < LANES; k++) sum_o += PART_W'(sq[k]);
  end
endmodule

// File: rtl/vqt_level.sv
module vqt_level
  import vqt_pkg::*;
#(
  parameter int LVL = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [PASS_W-1:0]  pass_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [PASS_W-1:0]  wr_chunk_i,
  input  logic [CHUNK_W-1:0] wr_data_i,
  input  logic               in_vld_i,
  input  logic [DESC_W-1:0]  in_desc_i,
  input  logic [NODE_W-1:0]  in_node_i,
  output logic               out_vld_o,
  output logic [DESC_W-1:0]  out_desc_o,
  output logic [NODE_W-1:0]  out_node_o
);
  localparam int NW    = 2 ** (LVL + 1);
  localparam int BASE  = NW - 2;
  localparam int DEPTH = NW * PASSES;
  localparam int MA_W  = $clog2(DEPTH);

  logic [CHUNK_W-1:0] mem_q [DEPTH];
  logic               vld_q;
  logic [DESC_W-1:0]  desc_q;
  logic [NODE_W-1:0]  node_q;
  logic [DIST_W-1:0]  accl_q, accr_q, suml, sumr;
  logic [PART_W-1:0]  part_l, part_r;
  logic [CHUNK_W-1:0] chunk;
  logic               hit, go_right;
  logic [MA_W-1:0]    widx, ridx_l, ridx_r;

  always_comb begin
    hit    = wr_en_i && (int'(wr_addr_i) >= BASE) && (int'(wr_addr_i) < BASE + NW);
    widx   = MA_W'((int'(wr_addr_i) - BASE) * PASSES + int'(wr_chunk_i));
    ridx_l = MA_W'((int'(node_q) * 2) * PASSES + int'(pass_i));
    ridx_r = MA_W'((int'(node_q) * 2 + 1) * PASSES + int'(pass_i));
    chunk  = desc_q[int'(pass_i)*CHUNK_W +: CHUNK_W];
  end

  always_ff @(posedge clk_i) begin
    if (hit) mem_q[widx] <= wr_data_i;
  end

  vqt_chunk_dist u_dist_l (.a_i(chunk), .b_i(mem_q[ridx_l]), .sum_o(part_l));
  vqt_chunk_dist u_dist_r (.a_i(chunk), .b_i(mem_q[ridx_r]), .sum_o(part_r));

  assign suml     = accl_q + DIST_W'(part_l);
  assign sumr     = accr_q + DIST_W'(part_r);
  assign go_right = sumr < suml;  // tie keeps the left child

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      desc_q <= '0;
      node_q <= '0;
      accl_q <= '0;
      accr_q <= '0;
    end else if (step_i) begin
      vld_q  <= in_vld_i;
      desc_q <= in_desc_i;
      node_q <= in_node_i;
      accl_q <= '0;
      accr_q <= '0;
    end else begin
      accl_q <= suml;
      accr_q <= sumr;
    end
  end

  assign out_vld_o  = vld_q;
  assign out_desc_o = desc_q;
  assign out_node_o = {node_q[NODE_W-2:0], go_right};

  // R6
  slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(vld_q) && $stable(node_q));
  // R1
  acc_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> (accl_q >= $past(accl_q)) && (accr_q >= $past(accr_q)));
endmodule

// File: rtl/vqt_hist.sv
module vqt_hist
  import vqt_pkg::*;
#(
  parameter int BIN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic [NODE_W-1:0] inc_bin_i,
  input  logic [NODE_W-1:0] rd_bin_i,
  output logic [BIN_W-1:0]  rd_cnt_o
);
  logic [BIN_W-1:0] bins_q [NBINS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NBINS; b++) bins_q[b] <= '0;
    end else if (clr_i) begin
      for (int b = 0; b < NBINS; b++) bins_q[b] <= '0;
    end else if (inc_i && (bins_q[inc_bin_i] != '1)) begin
      bins_q[inc_bin_i] <= bins_q[inc_bin_i] + 1'b1;
    end
  end

  assign rd_cnt_o = bins_q[rd_bin_i];

  for (genvar b = 0; b < NBINS; b++) begin : g_chk
    // R9
    bin_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && bins_q[b] == '1) |=> bins_q[b] == '1);
    // R8
    bin_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> bins_q[b] == '0);
  end
endmodule

// File: rtl/vqt_quantizer.sv
module vqt_quantizer
  import vqt_pkg::*;
#(
  parameter int BIN_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               desc_valid_i,
  output logic               desc_ready_o,
  input  logic [DESC_W-1:0]  desc_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [PASS_W-1:0]  wr_chunk_i,
  input  logic [CHUNK_W-1:0] wr_data_i,
  input  logic               clr_i,
  input  logic [NODE_W-1:0]  rd_bin_i,
  output logic [BIN_W-1:0]   rd_cnt_o
);
  localparam int GAP_W = $clog2(PASSES + 1);

  logic [PASS_W-1:0] pass_q;
  logic              step, accept;
  logic [GAP_W-1:0]  gap_q;

  logic              vld_c  [LEVELS+1];
  logic [DESC_W-1:0] desc_c [LEVELS+1];
  logic [NODE_W-1:0] node_c [LEVELS+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pass_q <= '0;
    else         pass_q <= step ? '0 : pass_q + 1'b1;
  end

  assign step         = pass_q == PASS_W'(PASSES - 1);
  assign desc_ready_o = step && !wr_en_i && !clr_i;
  assign accept       = desc_valid_i && desc_ready_o;

  assign vld_c[0]  = accept;
  assign desc_c[0] = desc_i;
  assign node_c[0] = '0;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    vqt_level #(.LVL(l)) u_lvl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .step_i     (step),
      .pass_i     (pass_q),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_chunk_i (wr_chunk_i),
      .wr_data_i  (wr_data_i),
      .in_vld_i   (vld_c[l]),
      .in_desc_i  (desc_c[l]),
      .in_node_i  (node_c[l]),
      .out_vld_o  (vld_c[l+1]),
      .out_desc_o (desc_c[l+1]),
      .out_node_o (node_c[l+1])
    );
  end

  vqt_hist #(.BIN_W(BIN_W)) u_hist (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .inc_i     (vld_c[LEVELS] && step),
    .inc_bin_i (node_c[LEVELS]),
    .rd_bin_i  (rd_bin_i),
    .rd_cnt_o  (rd_cnt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= GAP_W'(PASSES);
    else if (accept)                 gap_q <= '0;
    else if (gap_q < GAP_W'(PASSES)) gap_q <= gap_q + 1'b1;
  end

  // R6
  accept_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> gap_q >= GAP_W'(PASSES - 1));
  // R6
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !desc_ready_o);
endmodule

// File: tb/vqt_quantizer_tb_top.sv
`timescale 1ns/1ps
module vqt_quantizer_tb_top;
  import vqt_pkg::*;
  localparam int BW  = 8;
  localparam int MAXC = (1 << BW) - 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic desc_valid_i = 1'b0;
  logic desc_ready_o;
  logic [DESC_W-1:0] desc_i = '0;
  logic wr_en_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [PASS_W-1:0] wr_chunk_i = '0;
  logic [CHUNK_W-1:0] wr_data_i = '0;
  logic clr_i = 1'b0;
  logic [NODE_W-1:0] rd_bin_i = '0;
  logic [BW-1:0] rd_cnt_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] tw [NWORDS][DIM];
  int ref_cnt [NBINS];

  always #2 clk_i = ~clk_i;

  vqt_quantizer #(.BIN_W(BW)) dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int leaf_of(input logic [DESC_W-1:0] d);
    int node = 0;
    for (int l = 0; l < LEVELS; l++) begin
      int base = (2 << l) - 2;
      int wl = base + 2 * node;
      int dl = 0, dr = 0;
      for (int e = 0; e < DIM; e++) begin
        int x = int'(d[8*e +: 8]);
        dl += (x - int'(tw[wl][e])) * (x - int'(tw[wl][e]));
        dr += (x - int'(tw[wl+1][e])) * (x - int'(tw[wl+1][e]));
      end
      node = (dr < dl) ? 2 * node + 1 : 2 * node;
    end
    return node;
  endfunction

  task automatic write_tree();
    for (int a = 0; a < NWORDS; a++) begin
      for (int c = 0; c < PASSES; c++) begin
        @(negedge clk_i);
        wr_en_i = 1'b1; wr_addr_i = ADDR_W'(a); wr_chunk_i = PASS_W'(c);
        for (int j = 0; j < LANES; j++) wr_data_i[8*j +: 8] = tw[a][LANES*c + j];
      end
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic tree_lr(input int lv, input int rv);
    for (int a = 0; a < NWORDS; a++)
      for (int e = 0; e < DIM; e++) tw[a][e] = 8'((a % 2 == 0) ? lv : rv);
    write_tree();
  endtask

  task automatic tree_rand();
    for (int a = 0; a < NWORDS; a++)
      for (int e = 0; e < DIM; e++) tw[a][e] = 8'($urandom);
    write_tree();
  endtask

  function automatic logic [DESC_W-1:0] fill(input int v);
    logic [DESC_W-1:0] d;
    for (int e = 0; e < DIM; e++) d[8*e +: 8] = 8'(v);
    return d;
  endfunction

  function automatic logic [DESC_W-1:0] rnd_desc();
    logic [DESC_W-1:0] d;
    for (int e = 0; e < DIM; e++) d[8*e +: 8] = 8'($urandom);
    return d;
  endfunction

  // returns at the falling edge just after the accepting edge
  task automatic send(input logic [DESC_W-1:0] d);
    int lf = leaf_of(d);
    @(negedge clk_i);
    desc_i = d; desc_valid_i = 1'b1;
    #1;
    while (!desc_ready_o) begin @(negedge clk_i); #1; end
    @(negedge clk_i);
    desc_valid_i = 1'b0;
    if (ref_cnt[lf] < MAXC) ref_cnt[lf]++;
  endtask

  task automatic drain();
    repeat (56) @(negedge clk_i);
  endtask

  task automatic read_bin(input int b, output int v);
    rd_bin_i = NODE_W'(b);
    #1;
    v = int'(rd_cnt_o);
  endtask

  task automatic check_all(input string req);
    int v;
    for (int b = 0; b < NBINS; b++) begin
      read_bin(b, v);
      chk(req, v, ref_cnt[b]);
    end
  endtask

  task automatic do_clear();
    @(negedge clk_i);
    clr_i = 1'b1;
    #1;
    chk("R7 ready low during clear", int'(desc_ready_o), 0);
    @(negedge clk_i);
    clr_i = 1'b0;
    for (int b = 0; b < NBINS; b++) ref_cnt[b] = 0;
  endtask

  task automatic t_reset();
    check_all("R10 reset bins");
  endtask

  task automatic t_lr();
    tree_lr(0, 255);
    send(fill(127));            // nearer 0 at every level -> leaf 0
    send(fill(128));            // nearer 255 -> leaf 63
    send(fill(255));
    drain();
    chk("R1 leaf0 count", ref_cnt[0], 1);
    chk("R1 leaf63 count", ref_cnt[63], 2);
    check_all("R1 R4 left/right tree");
  endtask

  task automatic t_tie();
    do_clear();
    tree_lr(77, 77);
    for (int i = 0; i < 4; i++) send(rnd_desc());
    drain();
    chk("R2 tie model leaf", ref_cnt[0], 4);
    check_all("R2 tie takes left");
  endtask

  task automatic t_random();
    do_clear();
    tree_rand();
    for (int i = 0; i < 60; i++) send(rnd_desc());
    drain();
    check_all("R3 R4 random tree");
  endtask

  task automatic t_latency();
    int lf, v;
    logic [DESC_W-1:0] d = rnd_desc();
    lf = leaf_of(d);
    read_bin(lf, v);
    chk("R5 before send", v, ref_cnt[lf]);
    send(d);
    repeat (47) @(negedge clk_i);
    read_bin(lf, v);
    chk("R5 not yet at edge 47", v, ref_cnt[lf] - 1);
    @(negedge clk_i);
    read_bin(lf, v);
    chk("R5 visible at edge 48", v, ref_cnt[lf]);
  endtask

  task automatic t_stall();
    int rdy = 0;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = '0; wr_chunk_i = '0;
    for (int j = 0; j < LANES; j++) wr_data_i[8*j +: 8] = tw[0][j];
    desc_i = rnd_desc(); desc_valid_i = 1'b1;
    for (int i = 0; i < 24; i++) begin
      #1;
      if (desc_ready_o) rdy++;
      @(negedge clk_i);
    end
    wr_en_i = 1'b0; desc_valid_i = 1'b0;
    chk("R7 ready low while writing", rdy, 0);
    drain();
    check_all("R7 stalled valid ignored");
  endtask

  task automatic t_rate();
    int acc = 0, lf;
    do_clear();
    tree_lr(9, 9);
    @(negedge clk_i);
    desc_i = rnd_desc(); desc_valid_i = 1'b1;
    lf = leaf_of(desc_i);
    for (int i = 0; i < 80; i++) begin
      #1;
      if (desc_ready_o) acc++;
      @(negedge clk_i);
    end
    desc_valid_i = 1'b0;
    chk("R6 one ready per 8 cycles", acc, 10);
    ref_cnt[lf] += acc;
    drain();
    check_all("R6 R4 streamed count");
  endtask

  task automatic t_sat();
    int v;
    do_clear();
    for (int i = 0; i < MAXC + 40; i++) send(rnd_desc());
    drain();
    read_bin(0, v);
    chk("R9 saturated bin", v, MAXC);
    check_all("R9 saturation");
    do_clear();
    check_all("R8 clear zeroes all");
  endtask

  initial begin
    for (int b = 0; b < NBINS; b++) ref_cnt[b] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_lr();
    t_tie();
    t_random();
    t_latency();
    t_stall();
    t_rate();
    t_sat();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule